// File: doc/BRIEF.md
# Match Timer with Cross-Domain Clear

This block is a memory-mapped event timer. Software reaches it over a simple register bus that has separate read and write strobes, a byte address and 32-bit data. The counting logic runs from a slow timer clock that is independent of the bus clock. Once enabled, an up-counter advances on every divided timer tick and wraps to zero after all-ones. Whenever the count equals a programmed compare value, the block emits an interrupt pulse in the bus domain, meant for a rising-edge input.

An optional auto-zero bit makes the same counter restart from zero at each match, which gives periodic events. With the bit off, the counter runs freely and a single compare gives a one-shot event.

Writing to the zeroing register starts a request that crosses into the timer domain. A busy flag in the status word stays high until the timer domain has zeroed the counter and confirmed it back. Software polls this flag before it re-arms the timer. Configuration values and the count readback also cross the clock boundary through toggle handshakes. As a result, a multi-bit value is never sampled while it is changing.

Top module: `tmr_match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Byte offsets are: compare 0x00, count 0x04 (read-only, writes ignored), control 0x08, zeroing 0x0C, divider 0x10, status 0x14. Compare, control (bits 1:0) and divider read back what was written. Read data appears on the cycle after `bus_rd` and holds until the next read.
- R3: With control bit 0 set the counter advances. With it clear the counter holds its present value.
- R4: A divider value d makes the counter step once every d+1 timer clocks, so 3 gives one step per 4 timer clocks.
- R5: Any write to offset 0x0C zeroes the counter, whatever the data.
- R6: Status bit 10 reads 1 on the first read after a zeroing write and returns to 0 once the zeroing has completed in the timer domain.
- R7: Each match event gives exactly one `irq` pulse one bus cycle wide.
- R8: With control bit 1 clear, the counter keeps counting past the compare value.
- R9: With control bit 1 set, the counter returns to zero at the tick on which it equals the compare value. Events then repeat every (compare+1)·(d+1) timer clocks.
- R10: The counter wraps from all-ones to zero, so with auto-zero off the same compare value matches again after 2^width ticks.
- R11: `irq` is never asserted while control bit 0 is clear and was clear on the cycle before.
- R12: Successive count reads while running never decrease within one wrap period. The read value is a coherent snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_tmr | input | 1 | Timer clock |
| rst_tmr | input | 1 | Synchronous active-high reset, timer domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address within the block |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Registered read data |
| irq | output | 1 | One-cycle match pulse in the bus domain |

## Verification
The assertions assume a single-cycle strobe protocol on the bus. They also assume that both resets are held together for several cycles of the slower clock, so that each handshake starts from matched toggles. The bench drives the strobes only from the falling bus edge and holds reset for ten bus cycles. It uses fixed clock periods with a 3:1 ratio and an offset phase, which makes the crossing latency repeatable. Event intervals can therefore be compared exactly in bus cycles. Reconfiguration always follows a disable, a zeroing request and a poll of the busy flag, which is the sequence the block expects from software.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [4:0] OFS_MATCH = 5'h00;
  localparam logic [4:0] OFS_COUNT = 5'h04;
  localparam logic [4:0] OFS_CTRL  = 5'h08;
  localparam logic [4:0] OFS_ZERO  = 5'h0C;
  localparam logic [4:0] OFS_DIV   = 5'h10;
  localparam logic [4:0] OFS_STAT  = 5'h14;
  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_AUTO_BIT  = 1;
  localparam int STAT_BUSY_BIT  = 10;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stg_q[s] <= '0;
        end else if (s == 0) begin
          stg_q[s] <= d;
        end else begin
          stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int AW   = 5,
  parameter int BW   = 32,
  parameter int CW   = 32,
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  output logic            irq,
  output logic            en_o,
  output logic            busy_o,
  // toward timer domain
  output logic [CW-1:0]   x_match,
  output logic            x_run,
  output logic            x_auto,
  output logic [DIVW-1:0] x_div,
  output logic            cfg_req,
  output logic            zero_req,
  output logic            snap_ack,
  // from timer domain (raw)
  input  logic            cfg_ack_t,
  input  logic            zero_ack_t,
  input  logic            snap_req_t,
  input  logic [CW-1:0]   snap_val_t,
  input  logic            evt_tgl_t
);
  logic [CW-1:0]   match_q, cnt_q, xm_q;
  logic            run_q, auto_q, xr_q, xa_q;
  logic [DIVW-1:0] div_q, xd_q;
  logic            dirty_q, cfg_req_q, zero_req_q, snap_seen_q, evt_seen_q, irq_q;
  logic [BW-1:0]   rdata_q, rd_mux;
  logic            cfg_ack_s, zero_ack_s, snap_req_s, evt_tgl_s;

  tmr_sync #(.W(4), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .d({cfg_ack_t, zero_ack_t, snap_req_t, evt_tgl_t}),
    .q({cfg_ack_s, zero_ack_s, snap_req_s, evt_tgl_s})
  );

  logic hit_match, hit_ctrl, hit_zero, hit_div, cfg_wr, cfg_busy, busy, launch;
  assign hit_match = wr && (addr == AW'(OFS_MATCH));
  assign hit_ctrl  = wr && (addr == AW'(OFS_CTRL));
  assign hit_zero  = wr && (addr == AW'(OFS_ZERO));
  assign hit_div   = wr && (addr == AW'(OFS_DIV));
  assign cfg_wr    = hit_match || hit_ctrl || hit_div;
  assign cfg_busy  = cfg_req_q != cfg_ack_s;
  assign busy      = zero_req_q != zero_ack_s;
  assign launch    = dirty_q && !cfg_busy;

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(OFS_MATCH): rd_mux = BW'(match_q);
      AW'(OFS_COUNT): rd_mux = BW'(cnt_q);
      AW'(OFS_CTRL): begin
        rd_mux[CTRL_RUN_BIT]  = run_q;
        rd_mux[CTRL_AUTO_BIT] = auto_q;
      end
      AW'(OFS_DIV):  rd_mux = BW'(div_q);
      AW'(OFS_STAT): rd_mux[STAT_BUSY_BIT] = busy;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0; run_q <= 1'b0; auto_q <= 1'b0; div_q <= '0;
      xm_q <= '0; xr_q <= 1'b0; xa_q <= 1'b0; xd_q <= '0;
      dirty_q <= 1'b0; cfg_req_q <= 1'b0; zero_req_q <= 1'b0;
      snap_seen_q <= 1'b0; cnt_q <= '0; evt_seen_q <= 1'b0; irq_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (hit_match) match_q <= CW'(wdata);
      if (hit_ctrl) begin
        run_q  <= wdata[CTRL_RUN_BIT];
        auto_q <= wdata[CTRL_AUTO_BIT];
      end
      if (hit_div) div_q <= wdata[DIVW-1:0];
      if (launch) begin
        xm_q <= match_q; xr_q <= run_q; xa_q <= auto_q; xd_q <= div_q;
        cfg_req_q <= ~cfg_req_q;
      end
      if (cfg_wr) dirty_q <= 1'b1;
      else if (launch) dirty_q <= 1'b0;
      if (hit_zero && !busy) zero_req_q <= ~zero_req_q;
      if (snap_req_s != snap_seen_q) begin
        cnt_q       <= snap_val_t;
        snap_seen_q <= snap_req_s;
      end
      evt_seen_q <= evt_tgl_s;
      irq_q      <= (evt_tgl_s != evt_seen_q) && run_q;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata    = rdata_q;
  assign irq      = irq_q;
  assign en_o     = run_q;
  assign busy_o   = busy;
  assign x_match  = xm_q;
  assign x_run    = xr_q;
  assign x_auto   = xa_q;
  assign x_div    = xd_q;
  assign cfg_req  = cfg_req_q;
  assign zero_req = zero_req_q;
  assign snap_ack = snap_seen_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CW   = 32,
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   x_match,
  input  logic            x_run,
  input  logic            x_auto,
  input  logic [DIVW-1:0] x_div,
  input  logic            cfg_req_b,
  input  logic            zero_req_b,
  input  logic            snap_ack_b,
  output logic            cfg_ack,
  output logic            zero_ack,
  output logic            snap_req,
  output logic [CW-1:0]   snap_val,
  output logic            evt_tgl,
  output logic            en_o,
  output logic            tick_o,
  output logic            zero_o,
  output logic [CW-1:0]   cnt_o
);
  logic cfg_req_s, zero_req_s, snap_ack_s;

  tmr_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .d({cfg_req_b, zero_req_b, snap_ack_b}),
    .q({cfg_req_s, zero_req_s, snap_ack_s})
  );

  logic [CW-1:0]   match_q, cnt_q, snap_q;
  logic            run_q, auto_q, cfg_seen_q, zero_seen_q, snap_req_q, evt_q;
  logic [DIVW-1:0] div_q, presc_q;
  logic            cfg_evt, zero_evt, tick, hit;

  assign cfg_evt  = cfg_req_s != cfg_seen_q;
  assign zero_evt = zero_req_s != zero_seen_q;
  assign tick     = run_q && (presc_q == div_q) && !zero_evt;
  assign hit      = cnt_q == match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0; run_q <= 1'b0; auto_q <= 1'b0; div_q <= '0;
      cfg_seen_q <= 1'b0; zero_seen_q <= 1'b0; presc_q <= '0; cnt_q <= '0;
      evt_q <= 1'b0; snap_req_q <= 1'b0; snap_q <= '0;
    end else begin
      if (cfg_evt) begin
        match_q <= x_match; run_q <= x_run; auto_q <= x_auto; div_q <= x_div;
        cfg_seen_q <= cfg_req_s;
      end
      if (zero_evt) begin
        zero_seen_q <= zero_req_s;
        presc_q     <= '0;
      end else if (cfg_evt) begin
        presc_q <= '0;
      end else if (run_q) begin
        presc_q <= (presc_q == div_q) ? '0 : presc_q + 1'b1;
      end
      if (zero_evt) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (hit) evt_q <= ~evt_q;
        cnt_q <= (hit && auto_q) ? '0 : cnt_q + 1'b1;
      end
      if (snap_req_q == snap_ack_s) begin
        snap_q     <= cnt_q;
        snap_req_q <= ~snap_req_q;
      end
    end
  end

  assign cfg_ack  = cfg_seen_q;
  assign zero_ack = zero_seen_q;
  assign snap_req = snap_req_q;
  assign snap_val = snap_q;
  assign evt_tgl  = evt_q;
  assign en_o     = run_q;
  assign tick_o   = tick;
  assign zero_o   = zero_evt;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/tmr_match_timer.sv
module tmr_match_timer #(
  parameter int AW   = 5,
  parameter int BW   = 32,
  parameter int CW   = 32,
  parameter int DIVW = 2
) (
  input  logic          clk_bus,
  input  logic          rst_bus,
  input  logic          clk_tmr,
  input  logic          rst_tmr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          irq
);
  logic [CW-1:0]   x_match, snap_val, cnt_t;
  logic            x_run, x_auto, cfg_req, zero_req, snap_ack;
  logic [DIVW-1:0] x_div;
  logic            cfg_ack, zero_ack, snap_req, evt_tgl;
  logic            en_b, busy_b, en_t, tick_t, zero_t;

  tmr_bus_if #(.AW(AW), .BW(BW), .CW(CW), .DIVW(DIVW)) u_bus (
    .clk(clk_bus), .rst(rst_bus), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .irq(irq), .en_o(en_b), .busy_o(busy_b),
    .x_match(x_match), .x_run(x_run), .x_auto(x_auto), .x_div(x_div),
    .cfg_req(cfg_req), .zero_req(zero_req), .snap_ack(snap_ack),
    .cfg_ack_t(cfg_ack), .zero_ack_t(zero_ack), .snap_req_t(snap_req),
    .snap_val_t(snap_val), .evt_tgl_t(evt_tgl)
  );

  tmr_core #(.CW(CW), .DIVW(DIVW)) u_core (
    .clk(clk_tmr), .rst(rst_tmr),
    .x_match(x_match), .x_run(x_run), .x_auto(x_auto), .x_div(x_div),
    .cfg_req_b(cfg_req), .zero_req_b(zero_req), .snap_ack_b(snap_ack),
    .cfg_ack(cfg_ack), .zero_ack(zero_ack), .snap_req(snap_req),
    .snap_val(snap_val), .evt_tgl(evt_tgl),
    .en_o(en_t), .tick_o(tick_t), .zero_o(zero_t), .cnt_o(cnt_t)
  );
endmodule

// File: rtl/tmr_match_timer_chk.sv
module tmr_match_timer_chk
  import tmr_pkg::*;
#(
  parameter int AW = 5,
  parameter int BW = 32,
  parameter int CW = 32
) (
  input logic          clk_bus,
  input logic          rst_bus,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_rdata,
  input logic          irq,
  input logic          en_b,
  input logic          busy_b,
  input logic          clk_tmr,
  input logic          rst_tmr,
  input logic          en_t,
  input logic          tick_t,
  input logic          zero_t,
  input logic [CW-1:0] cnt_t
);
  a_r2_rdata_hold: assert property (@(posedge clk_bus) disable iff (rst_bus)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_irq_single: assert property (@(posedge clk_bus) disable iff (rst_bus)
    irq |=> !irq);

  a_r11_irq_gated: assert property (@(posedge clk_bus) disable iff (rst_bus)
    !$past(en_b) |-> !irq);

  a_r6_busy_set: assert property (@(posedge clk_bus) disable iff (rst_bus)
    (bus_wr && bus_addr == AW'(OFS_ZERO)) |=> busy_b);

  a_r3_hold_stopped: assert property (@(posedge clk_tmr) disable iff (rst_tmr)
    (!en_t && !zero_t) |=> $stable(cnt_t));

  a_r5_zeroed: assert property (@(posedge clk_tmr) disable iff (rst_tmr)
    zero_t |=> (cnt_t == '0));

  a_r10_wrap: assert property (@(posedge clk_tmr) disable iff (rst_tmr)
    (tick_t && cnt_t == '1) |=> (cnt_t == '0));
endmodule

bind tmr_match_timer tmr_match_timer_chk #(.AW(AW), .BW(BW), .CW(CW)) u_chk (
  .clk_bus(clk_bus), .rst_bus(rst_bus), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .en_b(en_b),
  .busy_b(busy_b), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr), .en_t(en_t),
  .tick_t(tick_t), .zero_t(zero_t), .cnt_t(cnt_t)
);

// File: tb/test_tmr_match_timer.sv
`timescale 1ns/1ps
module test_tmr_match_timer;
  localparam int AW = 5;
  localparam int BW = 32;
  localparam int CW = 10;
  localparam int DIVW = 2;
  localparam logic [4:0] A_MATCH = 5'h00, A_COUNT = 5'h04, A_CTRL = 5'h08,
                         A_ZERO = 5'h0C, A_DIV = 5'h10, A_STAT = 5'h14;
  localparam int TRATIO = 3; // timer period / bus period

  logic clk_bus = 1'b0, clk_tmr = 1'b0;
  logic rst_bus = 1'b1, rst_tmr = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic irq;

  always #2.5 clk_bus = ~clk_bus;
  initial begin
    #1;
    forever #7.5 clk_tmr = ~clk_tmr;
  end

  tmr_match_timer #(.AW(AW), .BW(BW), .CW(CW), .DIVW(DIVW)) i_tmr_match_timer (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_tmr(clk_tmr), .rst_tmr(rst_tmr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int irq_t[$];
  logic model_en = 1'b0, model_en_prev = 1'b0, irq_prev = 1'b0;
  logic monitor_on = 1'b0;

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model of the bus-visible interrupt behaviour, compared every cycle
  always @(negedge clk_bus) begin
    cyc++;
    if (monitor_on) begin
      check("R11", !(irq && !model_en && !model_en_prev), irq, 0);
      check("R7", !(irq && irq_prev), irq, 0);
      if (irq) irq_t.push_back(cyc);
    end
    irq_prev = irq;
    model_en_prev = model_en;
  end

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_wr = 1'b0;
    if (a == A_CTRL) model_en = d[0];
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk_bus);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_bus);
  endtask

  task automatic wait_idle_zero(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      bread(A_STAT, s);
      if (!s[10]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_irqs(input int n, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (irq_t.size() >= n) begin ok = 1'b1; break; end
      @(negedge clk_bus);
    end
  endtask

  task automatic arm(input logic [31:0] m, input logic [31:0] dv, input logic [31:0] ct);
    logic ok;
    bwrite(A_CTRL, 32'h0);
    idle(40);
    bwrite(A_ZERO, 32'h5A5A_0001);
    wait_idle_zero(ok);
    check("R6", ok, ok, 1);
    bwrite(A_MATCH, m);
    bwrite(A_DIV, dv);
    idle(30);
    irq_t.delete();
    bwrite(A_CTRL, ct);
  endtask

  // watchdog
  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk_bus);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2, prev;
    logic ok;
    int d;
    idle(10);
    rst_bus = 1'b0; rst_tmr = 1'b0;
    idle(5);
    monitor_on = 1'b1;

    // R1: reset values
    check("R1", irq == 1'b0, irq, 0);
    bread(A_MATCH, v); check("R1", v == 0, v, 0);
    bread(A_COUNT, v); check("R1", v == 0, v, 0);
    bread(A_CTRL, v);  check("R1", v == 0, v, 0);
    bread(A_DIV, v);   check("R1", v == 0, v, 0);
    bread(A_STAT, v);  check("R1", v == 0, v, 0);

    // R2: readback, count read-only
    bwrite(A_MATCH, 32'h155); bread(A_MATCH, v); check("R2", v == 32'h155, v, 32'h155);
    bwrite(A_CTRL, 32'h2);    bread(A_CTRL, v);  check("R2", v == 32'h2, v, 2);
    bwrite(A_DIV, 32'h2);     bread(A_DIV, v);   check("R2", v == 32'h2, v, 2);
    bwrite(A_COUNT, 32'h77); idle(30);
    bread(A_COUNT, v); check("R2", v == 0, v, 0);

    // R3: counting and holding
    arm(32'h3FF, 0, 32'h1);
    idle(100);
    bread(A_COUNT, c1); check("R3", c1 > 0, c1, 1);
    idle(60);
    bread(A_COUNT, c2); check("R3", c2 > c1, c2, c1 + 1);
    bwrite(A_CTRL, 32'h0);
    idle(40);
    bread(A_COUNT, c1);
    idle(100);
    bread(A_COUNT, c2); check("R3", c2 == c1, c2, c1);

    // R5/R6: zeroing with arbitrary data, busy flag
    bwrite(A_ZERO, 32'hDEAD_BEEF);
    bread(A_STAT, v); check("R6", v[10] == 1'b1, v[10], 1);
    wait_idle_zero(ok); check("R6", ok, ok, 1);
    idle(30);
    bread(A_COUNT, v); check("R5", v == 0 && c1 != 0, v, 0);

    // R9/R4: periodic, divider 3, compare 4
    arm(32'd4, 32'd3, 32'h3);
    wait_irqs(4, ok); check("R9", ok, irq_t.size(), 4);
    if (ok) begin
      d = irq_t[2] - irq_t[1]; check("R4", d == 5*4*TRATIO, d, 5*4*TRATIO);
      d = irq_t[3] - irq_t[2]; check("R9", d == 5*4*TRATIO, d, 5*4*TRATIO);
    end
    bwrite(A_CTRL, 32'h0); idle(40);
    bread(A_COUNT, v); check("R9", v <= 4, v, 4);

    // R9: periodic, divider 0, compare 9
    arm(32'd9, 32'd0, 32'h3);
    wait_irqs(3, ok); check("R9", ok, irq_t.size(), 3);
    if (ok) begin
      d = irq_t[2] - irq_t[1]; check("R9", d == 10*TRATIO, d, 10*TRATIO);
    end

    // R8/R10: free run past compare and wrap
    arm(32'd20, 32'd0, 32'h1);
    wait_irqs(1, ok); check("R7", ok, irq_t.size(), 1);
    idle(50);
    bread(A_COUNT, v); check("R8", v > 20, v, 21);
    check("R8", irq_t.size() == 1, irq_t.size(), 1);
    wait_irqs(2, ok); check("R10", ok, irq_t.size(), 2);
    if (ok) begin
      d = irq_t[1] - irq_t[0];
      check("R10", d == (1 << CW) * TRATIO, d, (1 << CW) * TRATIO);
    end

    // R11: no pulse after disable although events would follow
    arm(32'd0, 32'd0, 32'h3);
    idle(20);
    bwrite(A_CTRL, 32'h0);
    idle(5);
    irq_t.delete();
    idle(200);
    check("R11", irq_t.size() == 0, irq_t.size(), 0);

    // R12: snapshot reads monotonic
    arm(32'h3FF, 32'd3, 32'h1);
    prev = 0;
    for (int k = 0; k < 8; k++) begin
      idle(7);
      bread(A_COUNT, v);
      check("R12", v >= prev && v < (1 << CW), v, prev);
      prev = v;
    end
    bwrite(A_CTRL, 32'h0);
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule